// File: doc/BRIEF.md
# Table-Coded Clock Divider

This block divides a source clock by a ratio that is looked up from a small 3-bit code through one of four fixed encoding tables. A 2-bit table selector picks how the code is read. Two of the tables send codes 0 and 1 to the same ratio, and the ratios they produce can be odd as well as even. The result is a clock output that other logic can use at a fraction of the source rate.

A gate enable sits in front of the divider. While the gate is closed, the output is held low. When the gate opens again, the output starts a fresh period from its first high cycle.

The code and the table selector may change at any time. The divider only takes the new ratio at the end of the period in progress, so a change never shortens a high or low phase into a runt pulse. The output comes straight from a flop clocked by the source clock, so it carries no combinational glitches.

Top module: `tcdiv_top`

## Requirements
- R1: While `rst_n` is low, `clk_div` is 0. After reset is released with `gate_en` high, the first rising source edge makes `clk_div` 1.
- R2: With `tbl_mode` = 0 (engine table), codes 0 and 1 divide by 2, and each code n from 2 to 7 divides by n+1.
- R3: With `tbl_mode` = 1 (MAC table), codes 0 and 1 divide by 4, and each code n from 2 to 7 divides by 2*(n+1).
- R4: With `tbl_mode` = 2 (general table), each code n divides by 4*(n+1), which covers 4 to 32.
- R5: With `tbl_mode` = 3 (low-speed table), each code n divides by 2*(n+1).
- R6: A period of N source cycles has floor(N/2) high cycles followed by N-floor(N/2) low cycles. Even N therefore gives 50% duty, and odd N gives a high phase one cycle shorter than the low phase.
- R7: A change of `sel` or `tbl_mode` during a period leaves that period at its old length. The new ratio takes effect from the next period.
- R8: A source edge that samples `gate_en` low drives `clk_div` to 0, and it stays 0 for as long as the gate is closed.
- R9: The first source edge that samples `gate_en` high after a closed gate drives `clk_div` to 1 and starts a full period, using the ratio selected at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Source clock to be divided |
| rst_n | input | 1 | Active-low reset, synchronous to clk_src |
| gate_en | input | 1 | Gate in front of the divider; 0 holds the output low |
| sel | input | SEL_W (3) | Ratio code, looked up through the chosen table |
| tbl_mode | input | 2 | Table choice: 0 engine, 1 MAC, 2 general, 3 low-speed |
| clk_div | output | 1 | Divided clock, registered on clk_src |

## Verification
The assertions assume that `gate_en`, `sel` and `tbl_mode` are synchronous to `clk_src` and settle well before each rising edge. They make no assumption about how often or when those inputs change. The bench keeps to this by changing every input a short time after a falling edge. Random changes of code, table and gate land at arbitrary phases of the period, so the bound checks on high and low run lengths and the gate properties see runt-prone moments. Directed cases cover every code in every table, a change of ratio in the middle of a period, and closing and reopening the gate.

// File: rtl/tcdiv_pkg.sv
package tcdiv_pkg;

    localparam int unsigned MODE_W    = 2;
    localparam int unsigned NUM_MODES = 1 << MODE_W;

    typedef enum logic [MODE_W-1:0] {
        TBL_ENGINE  = 2'd0,
        TBL_MAC     = 2'd1,
        TBL_GENERAL = 2'd2,
        TBL_SLOW    = 2'd3
    } tbl_mode_e;

    // Division ratio for a code under a given table.
    function automatic int unsigned tbl_ratio(tbl_mode_e m, int unsigned code);
        int unsigned r;
        case (m)
            TBL_ENGINE:  r = (code < 2) ? 2 : code + 1;
            TBL_MAC:     r = (code < 2) ? 4 : 2 * (code + 1);
            TBL_GENERAL: r = 4 * (code + 1);
            default:     r = 2 * (code + 1);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tcdiv_ratio_lut.sv
module tcdiv_ratio_lut
    import tcdiv_pkg::*;
#(
    parameter int unsigned SEL_W = 3,
    parameter int unsigned RAT_W = SEL_W + 3
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [MODE_W-1:0] tbl_mode,
    output logic [RAT_W-1:0]  ratio
);

    logic [RAT_W-1:0] cand [NUM_MODES];

    // One candidate ratio per table, picked afterwards by the mode.
    for (genvar g = 0; g < NUM_MODES; g++) begin : g_tbl
        assign cand[g] = RAT_W'(tbl_ratio(tbl_mode_e'(g), int'(sel)));
    end

    assign ratio = cand[tbl_mode];

endmodule

// File: rtl/tcdiv_core.sv
module tcdiv_core #(
    parameter int unsigned RAT_W = 6
) (
    input  logic             clk_src,
    input  logic             rst_n,
    input  logic             gate_en,
    input  logic [RAT_W-1:0] ratio_in,
    output logic             clk_div
);

    typedef struct packed {
        logic             run;
        logic [RAT_W-1:0] cnt;
        logic [RAT_W-1:0] ratio;
        logic             out;
    } core_st_t;

    core_st_t st_d, st_q;

    logic [RAT_W-1:0] half_q;
    logic             last_q;

    assign half_q = st_q.ratio >> 1;
    assign last_q = (st_q.cnt == st_q.ratio - 1'b1);

    always_comb begin
        st_d = st_q;
        if (!gate_en) begin
            // closed gate: hold low and forget the phase
            st_d.run = 1'b0;
            st_d.cnt = '0;
            st_d.out = 1'b0;
        end else if (!st_q.run || last_q) begin
            // period boundary: only here a new ratio is taken
            st_d.run   = 1'b1;
            st_d.cnt   = '0;
            st_d.ratio = ratio_in;
            st_d.out   = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
            st_d.out = (st_d.cnt < half_q);
        end
    end

    always_ff @(posedge clk_src) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_div = st_q.out;

endmodule

// File: rtl/tcdiv_top.sv
module tcdiv_top
    import tcdiv_pkg::*;
#(
    parameter int unsigned SEL_W = 3
) (
    input  logic              clk_src,
    input  logic              rst_n,
    input  logic              gate_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [MODE_W-1:0] tbl_mode,
    output logic              clk_div
);

    localparam int unsigned RAT_W   = SEL_W + 3;
    localparam int unsigned RAT_MAX = 4 << SEL_W;

    logic [RAT_W-1:0] ratio;

    tcdiv_ratio_lut #(
        .SEL_W (SEL_W),
        .RAT_W (RAT_W)
    ) u_lut (
        .sel      (sel),
        .tbl_mode (tbl_mode),
        .ratio    (ratio)
    );

    tcdiv_core #(
        .RAT_W (RAT_W)
    ) u_core (
        .clk_src  (clk_src),
        .rst_n    (rst_n),
        .gate_en  (gate_en),
        .ratio_in (ratio),
        .clk_div  (clk_div)
    );

endmodule

// File: rtl/tcdiv_chk.sv
module tcdiv_chk #(
    parameter int unsigned RAT_MAX = 32
) (
    input logic clk_src,
    input logic rst_n,
    input logic gate_en,
    input logic clk_div
);

    logic [7:0] hi_run_q;
    logic [7:0] lo_run_q;

    // run lengths counted at source edges, saturating
    always_ff @(posedge clk_src) begin
        if (!rst_n) begin
            hi_run_q <= '0;
            lo_run_q <= '0;
        end else begin
            hi_run_q <= clk_div ? ((hi_run_q == 8'hff) ? hi_run_q : hi_run_q + 1'b1) : '0;
            lo_run_q <= (clk_div || !gate_en) ? '0
                      : ((lo_run_q == 8'hff) ? lo_run_q : lo_run_q + 1'b1);
        end
    end

    AST_GATED_LOW: assert property (@(posedge clk_src) disable iff (!rst_n)
        !gate_en |=> !clk_div); // R8

    AST_RESTART_HIGH: assert property (@(posedge clk_src) disable iff (!rst_n)
        $rose(gate_en) |=> clk_div); // R9

    AST_HIGH_BOUND: assert property (@(posedge clk_src) disable iff (!rst_n)
        int'(hi_run_q) <= RAT_MAX / 2); // R6

    AST_LOW_BOUND: assert property (@(posedge clk_src) disable iff (!rst_n)
        int'(lo_run_q) <= RAT_MAX - RAT_MAX / 2); // R6

endmodule

bind tcdiv_top tcdiv_chk #(.RAT_MAX(RAT_MAX)) u_chk (
    .clk_src (clk_src),
    .rst_n   (rst_n),
    .gate_en (gate_en),
    .clk_div (clk_div)
);

// File: tb/tcdiv_top_test.sv
`timescale 1ns/1ps
module tcdiv_top_test;

    logic       clk_src = 1'b0;
    logic       rst_n   = 1'b0;
    logic       gate_en = 1'b0;
    logic [2:0] sel     = 3'd0;
    logic [1:0] tbl_mode = 2'd0;
    logic       clk_div;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    tcdiv_top uut (
        .clk_src  (clk_src),
        .rst_n    (rst_n),
        .gate_en  (gate_en),
        .sel      (sel),
        .tbl_mode (tbl_mode),
        .clk_div  (clk_div)
    );

    always #2.5 clk_src = ~clk_src;

    // expected ratio, written from the table requirements
    function automatic int exp_ratio(int md, int code);
        case (md)
            0: return (code <= 1) ? 2 : code + 1;       // R2
            1: return (code <= 1) ? 4 : 2 * code + 2;   // R3
            2: return 4 * code + 4;                     // R4
            default: return 2 * code + 2;               // R5
        endcase
    endfunction

    function automatic string mode_tag(int md);
        case (md)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // waveform model: period counter, ratio, gate seen at last edge
    bit m_run  = 0;
    int m_cnt  = 0;
    int m_n    = 2;
    bit m_out  = 0;
    bit m_gate = 0;

    always @(posedge clk_src) begin
        cyc++;
        m_gate = gate_en;
        if (!rst_n || !gate_en) begin
            m_run = 0;
            m_cnt = 0;
            m_out = 0;
        end else if (!m_run || m_cnt == m_n - 1) begin
            m_run = 1;
            m_cnt = 0;
            m_n   = exp_ratio(int'(tbl_mode), int'(sel));
            m_out = 1;
        end else begin
            m_cnt++;
            m_out = (m_cnt < m_n / 2);
        end
    end

    always @(negedge clk_src) begin
        if (!rst_n) begin
            chk(clk_div == 1'b0, "R1", int'(clk_div), 0);
        end else if (!m_gate) begin
            chk(clk_div == m_out, "R8", int'(clk_div), int'(m_out));
        end else if (m_cnt == 0) begin
            chk(clk_div == m_out, "R9", int'(clk_div), int'(m_out));
        end else begin
            chk(clk_div == m_out, "R6", int'(clk_div), int'(m_out));
        end
    end

    // watchdog
    always @(posedge clk_src) begin
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            finish_up();
        end
    end

    task automatic measure(input int md, input int sl);
        int hi;
        int lo;
        int n;
        @(negedge clk_src); #1 gate_en = 1'b0;
        @(negedge clk_src); #1 tbl_mode = 2'(md); sel = 3'(sl); gate_en = 1'b1;
        @(negedge clk_src);
        hi = 0;
        while (clk_div) begin hi++; @(negedge clk_src); end
        lo = 0;
        while (!clk_div) begin lo++; @(negedge clk_src); end
        n = exp_ratio(md, sl);
        chk(hi + lo == n, mode_tag(md), hi + lo, n);
        chk(hi == n / 2, "R6", hi, n / 2);
    endtask

    initial begin
        int total;
        int hi;
        int lo;
        bit seen_low;
        void'($urandom(32'd20240611));

        // R1: reset state, then start with the gate already open
        repeat (4) @(negedge clk_src);
        chk(clk_div == 1'b0, "R1", int'(clk_div), 0);
        #1 gate_en = 1'b1;
        rst_n = 1'b1;
        @(negedge clk_src);
        chk(clk_div == 1'b1, "R1", int'(clk_div), 1);

        // R2..R5, R6: every code in every table
        for (int md = 0; md < 4; md++) begin
            for (int sl = 0; sl < 8; sl++) begin
                measure(md, sl);
            end
        end

        // R7: ratio change in the middle of a 32-cycle period
        @(negedge clk_src); #1 gate_en = 1'b0;
        @(negedge clk_src); #1 tbl_mode = 2'd2; sel = 3'd7; gate_en = 1'b1;
        @(negedge clk_src);
        total = 0;
        seen_low = 0;
        forever begin
            total++;
            if (total == 3) begin #1 sel = 3'd0; tbl_mode = 2'd0; end
            @(negedge clk_src);
            if (!clk_div) seen_low = 1;
            if (clk_div && seen_low) break;
        end
        chk(total == 32, "R7", total, 32);
        hi = 0;
        while (clk_div) begin hi++; @(negedge clk_src); end
        lo = 0;
        while (!clk_div) begin lo++; @(negedge clk_src); end
        chk(hi + lo == 2, "R7", hi + lo, 2);

        // R8: closing the gate mid-period holds the output low
        #1 tbl_mode = 2'd1; sel = 3'd7;
        repeat (5) @(negedge clk_src);
        #1 gate_en = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk_src);
            chk(clk_div == 1'b0, "R8", int'(clk_div), 0);
        end

        // R9: reopening restarts a full period with the current code
        #1 sel = 3'd2;
        #1 gate_en = 1'b1;
        @(negedge clk_src);
        chk(clk_div == 1'b1, "R9", int'(clk_div), 1);
        hi = 0;
        while (clk_div) begin hi++; @(negedge clk_src); end
        chk(hi == 3, "R9", hi, 3);

        // random phase: codes, tables and gate change at any point
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk_src);
            #1;
            if ($urandom % 8 == 0) sel = 3'($urandom % 8);
            if ($urandom % 24 == 0) tbl_mode = 2'($urandom % 4);
            if (gate_en) begin
                if ($urandom % 80 == 0) gate_en = 1'b0;
            end else begin
                if ($urandom % 4 == 0) gate_en = 1'b1;
            end
        end

        repeat (2) @(negedge clk_src);
        finish_up();
    end

endmodule